// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block decides, at each instruction boundary of a small processor core, whether an interrupt is accepted and which handler address the core jumps to. It keeps a set of request flags, a matching set of enable bits and a master enable with a one-instruction delay stage in front of it. It also tracks whether the core is halted. Peripherals raise single-cycle request pulses. The core's decoder reports the enable, disable, return-from-interrupt and halt instructions as strobes, and reports each instruction boundary with a strobe as well. Software reads and writes the flag and enable registers through a small register port.

When an interrupt is accepted, the block raises a one-cycle take strobe alongside the handler address. In the same step it clears the accepted request flag, drops the master enable and leaves the halted state. Saving the program counter and running the handler are the core's job.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, every request flag and enable bit is zero and the master enable and its delay stage are clear. take_o and halted_o are low, and both register read ports return 0xE0.
- R2: take_o is high only in a cycle with boundary_i high, the master enable set and at least one source both flagged and enabled.
- R3: When several enabled sources are pending, the lowest-numbered one is accepted. vector_o then equals 0x40 + 8*n for source n (0 to 4).
- R4: Accepting source n clears request flag n and leaves the other flags unchanged.
- R5: Accepting an interrupt clears the master enable and its delay stage, so the next boundary takes nothing unless a return-from-interrupt arrived in between.
- R6: op_ei_i only sets the delay stage. The master enable copies that stage at the following boundary, so the first boundary after the one carrying op_ei_i still takes nothing.
- R7: op_di_i clears the master enable, the delay stage and the halted state from the next cycle on.
- R8: op_reti_i sets the master enable and the delay stage at once, so the next boundary with a pending enabled source takes it.
- R9: op_halt_i sets halted_o from the next cycle. With the master enable set, any flagged-and-enabled source clears it one cycle later. With the master enable clear, halted_o stays high.
- R10: A request pulse on req_i[n] sets flag n. A register write with reg_sel_i = 0 replaces the flags with reg_wdata_i, but a request in the same cycle still sets its flag.
- R11: A register write with reg_sel_i = 1 loads the enable bits. Both read ports return the five bits in positions 4..0 with bits 7..5 reading as ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 5 | Peripheral request pulses, bit n for source n |
| boundary_i | input | 1 | Instruction boundary: interrupt check point |
| op_ei_i | input | 1 | Enable-interrupts instruction decoded |
| op_di_i | input | 1 | Disable-interrupts instruction decoded |
| op_reti_i | input | 1 | Return-from-interrupt instruction decoded |
| op_halt_i | input | 1 | Halt instruction decoded |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the flag register, 1 the enable register |
| reg_wdata_i | input | 5 | Register write data |
| flag_rdata_o | output | 8 | Request flags, upper bits ones |
| enable_rdata_o | output | 8 | Enable bits, upper bits ones |
| take_o | output | 1 | Interrupt accepted this cycle |
| vector_o | output | 16 | Handler address, valid with take_o |
| halted_o | output | 1 | Core is halted |

## Verification
The flag register can see a software write, a peripheral request and the clear caused by an accepted interrupt all in one cycle. The master enable can likewise see a boundary copy together with an instruction strobe. The stimulus table sets up these collisions on purpose: a return-from-interrupt arrives in the same cycle as a flag write and a request pulse, and an enable strobe rides on a boundary. The result is judged from the next read-back value and from the boundary at which the take strobe first appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic {
    SEL_FLAG   = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, base;

  // write replaces, else accept clears; requests always win
  always_comb begin
    base = wr_i ? wdata_i : (flags_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= base | req_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 5,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign onehot_o[g] = pend_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | pend_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_master_ctl.sv
module irq_master_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic take_i,
  input  logic pend_any_i,
  input  logic op_ei_i,
  input  logic op_di_i,
  input  logic op_reti_i,
  input  logic op_halt_i,
  output logic ime_o,
  output logic halted_o
);
  logic ime_q, ima_q, halt_q;
  logic ime_d, ima_d, halt_d;

  // order: wake check, boundary copy, accept, then the instruction's own effect
  always_comb begin
    ime_d  = ime_q;
    ima_d  = ima_q;
    halt_d = halt_q;
    if (halt_q && ime_q && pend_any_i) halt_d = 1'b0;
    if (boundary_i) ime_d = take_i ? 1'b0 : ima_q;
    if (take_i) begin
      ima_d  = 1'b0;
      halt_d = 1'b0;
    end
    if (op_halt_i) halt_d = 1'b1;
    if (op_ei_i)   ima_d  = 1'b1;
    if (op_reti_i) begin
      ime_d = 1'b1;
      ima_d = 1'b1;
    end
    if (op_di_i) begin
      ime_d  = 1'b0;
      ima_d  = 1'b0;
      halt_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q  <= 1'b0;
      ima_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      ime_q  <= ime_d;
      ima_q  <= ima_d;
      halt_q <= halt_d;
    end
  end

  assign ime_o    = ime_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int                NUM_SRC    = 5,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
  parameter int                VEC_STRIDE = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic                     boundary_i,
  input  logic                     op_ei_i,
  input  logic                     op_di_i,
  input  logic                     op_reti_i,
  input  logic                     op_halt_i,
  input  logic                     reg_wr_i,
  input  logic                     reg_sel_i,
  input  logic [NUM_SRC-1:0]       reg_wdata_i,
  output logic [irq_pkg::REG_W-1:0] flag_rdata_o,
  output logic [irq_pkg::REG_W-1:0] enable_rdata_o,
  output logic                     take_o,
  output logic [ADDR_W-1:0]        vector_o,
  output logic                     halted_o
);
  import irq_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] flags, enables_q, pend, onehot, clr;
  logic [IDX_W-1:0]   idx;
  logic               pend_any, ime, take;
  logic               wr_flag, wr_enable;

  assign wr_flag   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_FLAG);
  assign wr_enable = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_ENABLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        enables_q <= '0;
    else if (wr_enable) enables_q <= reg_wdata_i;
  end

  irq_flag_reg #(.N(NUM_SRC)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_i    (wr_flag),
    .wdata_i (reg_wdata_i),
    .clr_i   (clr),
    .flags_o (flags)
  );

  assign pend = flags & enables_q;

  irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) i_prio (
    .pend_i   (pend),
    .any_o    (pend_any),
    .onehot_o (onehot),
    .idx_o    (idx)
  );

  irq_master_ctl i_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .take_i     (take),
    .pend_any_i (pend_any),
    .op_ei_i    (op_ei_i),
    .op_di_i    (op_di_i),
    .op_reti_i  (op_reti_i),
    .op_halt_i  (op_halt_i),
    .ime_o      (ime),
    .halted_o   (halted_o)
  );

  assign take = boundary_i & ime & pend_any;
  assign clr  = take ? onehot : '0;

  always_comb begin
    vector_o = '0;
    if (take) vector_o = VEC_BASE + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
  end

  always_comb begin
    flag_rdata_o   = '1;
    enable_rdata_o = '1;
    flag_rdata_o[NUM_SRC-1:0]   = flags;
    enable_rdata_o[NUM_SRC-1:0] = enables_q;
  end

  assign take_o = take;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int                NUM_SRC    = 5,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0040,
  parameter int                VEC_STRIDE = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        req_i,
  input logic                      boundary_i,
  input logic                      op_ei_i,
  input logic                      op_di_i,
  input logic                      op_reti_i,
  input logic                      op_halt_i,
  input logic                      reg_wr_i,
  input logic                      reg_sel_i,
  input logic [NUM_SRC-1:0]        reg_wdata_i,
  input logic [irq_pkg::REG_W-1:0] flag_rdata_o,
  input logic [irq_pkg::REG_W-1:0] enable_rdata_o,
  input logic                      take_o,
  input logic [ADDR_W-1:0]         vector_o,
  input logic                      halted_o
);
  localparam logic [ADDR_W-1:0] VEC_TOP = VEC_BASE + ADDR_W'(VEC_STRIDE * (NUM_SRC - 1));

  logic [NUM_SRC-1:0] src_mask, taken_mask_q, pend;
  logic [ADDR_W-1:0]  vec_off;

  assign pend    = flag_rdata_o[NUM_SRC-1:0] & enable_rdata_o[NUM_SRC-1:0];
  assign vec_off = (vector_o - VEC_BASE) / ADDR_W'(VEC_STRIDE);

  always_comb begin
    src_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vec_off == ADDR_W'(i)) src_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_mask_q <= '0;
    else         taken_mask_q <= take_o ? src_mask : '0;
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> boundary_i);  // R2

  AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (pend != '0));  // R2

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vector_o >= VEC_BASE && vector_o <= VEC_TOP && $onehot0(src_mask) && src_mask != '0));  // R3

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((pend & (src_mask - 1'b1)) == '0));  // R3

  AST_TAKE_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !(reg_wr_i && !reg_sel_i) && req_i == '0) |=> ((flag_rdata_o[NUM_SRC-1:0] & taken_mask_q) == '0));  // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !op_reti_i) |=> !take_o);  // R5

  AST_DI_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_di_i |=> (!take_o && !halted_o));  // R7

  AST_HALT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_halt_i && !op_di_i) |=> halted_o);  // R9

  AST_REQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((flag_rdata_o[NUM_SRC-1:0] & $past(req_i)) == $past(req_i)));  // R10

  AST_UPPER_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rdata_o[irq_pkg::REG_W-1:NUM_SRC] == '1) && (enable_rdata_o[irq_pkg::REG_W-1:NUM_SRC] == '1));  // R11
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .NUM_SRC    (NUM_SRC),
  .ADDR_W     (ADDR_W),
  .VEC_BASE   (VEC_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) i_irq_dispatch_chk (.*);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  req_i = '0;
  logic        boundary_i = 1'b0, op_ei_i = 1'b0, op_di_i = 1'b0;
  logic        op_reti_i = 1'b0, op_halt_i = 1'b0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [4:0]  reg_wdata_i = '0;
  logic [7:0]  flag_rdata_o, enable_rdata_o;
  logic        take_o, halted_o;
  logic [15:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_dispatch i_irq_dispatch (
    .clk_i, .rst_ni, .req_i, .boundary_i, .op_ei_i, .op_di_i, .op_reti_i,
    .op_halt_i, .reg_wr_i, .reg_sel_i, .reg_wdata_i, .flag_rdata_o,
    .enable_rdata_o, .take_o, .vector_o, .halted_o
  );

  // {req, bnd, ei, di, reti, halt, wr, sel, wdata, exp_take, exp_vec, exp_halt, exp_flag}
  localparam int ROWS = 20;
  localparam logic [45:0] TBL [ROWS] = '{
    {5'h00, 7'b0000011, 8'h1F, 1'b0, 16'h0000, 1'b0, 8'hE0},
    {5'h06, 7'b0000000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hE0},
    {5'h00, 7'b1100000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hE6},
    {5'h00, 7'b1000000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hE6},
    {5'h00, 7'b1000000, 8'h00, 1'b1, 16'h0048, 1'b0, 8'hE6},
    {5'h00, 7'b1000000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hE4},
    {5'h00, 7'b0001000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hE4},
    {5'h00, 7'b1000000, 8'h00, 1'b1, 16'h0050, 1'b0, 8'hE4},
    {5'h02, 7'b0001010, 8'h11, 1'b0, 16'h0000, 1'b0, 8'hE0},
    {5'h00, 7'b1000000, 8'h00, 1'b1, 16'h0040, 1'b0, 8'hF3},
    {5'h00, 7'b0000100, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b0000000, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hF2},
    {5'h00, 7'b0001000, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hF2},
    {5'h00, 7'b0000000, 8'h00, 1'b0, 16'h0000, 1'b1, 8'hF2},
    {5'h00, 7'b0000000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b0010000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b1000000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b0000011, 8'h10, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b0001000, 8'h00, 1'b0, 16'h0000, 1'b0, 8'hF2},
    {5'h00, 7'b1000000, 8'h00, 1'b1, 16'h0060, 1'b0, 8'hF2}
  };

  function automatic string row_tag(int r);
    case (r)
      0, 17:          return "R11";
      1, 8:           return "R10";
      2:              return "R2";
      3:              return "R6";
      4, 9, 19:       return "R3";
      5:              return "R5";
      6, 7, 18:       return "R8";
      10:             return "R4";
      15, 16:         return "R7";
      default:        return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_i = '0; boundary_i = 0; op_ei_i = 0; op_di_i = 0; op_reti_i = 0;
    op_halt_i = 0; reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 take", 16'(take_o), 16'h0);
    check("R1 halted", 16'(halted_o), 16'h0);
    check("R1 flag", 16'(flag_rdata_o), 16'h00E0);
    check("R1 enable", 16'(enable_rdata_o), 16'h00E0);
    rst_ni = 1'b1;

    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk_i);
      req_i       = TBL[r][45:41];
      boundary_i  = TBL[r][40];
      op_ei_i     = TBL[r][39];
      op_di_i     = TBL[r][38];
      op_reti_i   = TBL[r][37];
      op_halt_i   = TBL[r][36];
      reg_wr_i    = TBL[r][35];
      reg_sel_i   = TBL[r][34];
      reg_wdata_i = TBL[r][30:26];
      #2;
      check(row_tag(r), 16'(take_o), 16'(TBL[r][25]));
      if (TBL[r][25]) check(row_tag(r), vector_o, TBL[r][24:9]);
      check(row_tag(r), 16'(halted_o), 16'(TBL[r][8]));
      check(row_tag(r), 16'(flag_rdata_o), 16'(TBL[r][7:0]));
    end

    // R11 enable write and readback with upper ones
    @(negedge clk_i); idle_inputs();
    reg_wr_i = 1; reg_sel_i = 1; reg_wdata_i = 5'h1F;
    @(negedge clk_i); idle_inputs(); #2;
    check("R11 enable", 16'(enable_rdata_o), 16'h00FF);

    // R7 disable releases halt
    op_halt_i = 1;
    @(negedge clk_i); idle_inputs(); #2;
    check("R9 halt set", 16'(halted_o), 16'h1);
    op_di_i = 1;
    @(negedge clk_i); idle_inputs(); #2;
    check("R7 di clears halt", 16'(halted_o), 16'h0);

    // R10 write replaces rather than merges (flags hold 0x02)
    reg_wr_i = 1; reg_sel_i = 0; reg_wdata_i = 5'h04;
    @(negedge clk_i); idle_inputs(); #2;
    check("R10 replace", 16'(flag_rdata_o), 16'h00E4);

    // R1 reset again from a busy state
    rst_ni = 1'b0;
    #1;
    check("R1 flag after reset", 16'(flag_rdata_o), 16'h00E0);
    check("R1 enable after reset", 16'(enable_rdata_o), 16'h00E0);
    check("R1 halted after reset", 16'(halted_o), 16'h0);
    @(negedge clk_i);
    finish_run();
  end
endmodule